// File: doc/BRIEF.md
# Single-Precision Operand Class Decoder

This stage inspects one 32-bit binary floating-point operand (1 sign bit, 8-bit exponent biased by 127, 23-bit fraction) and tells the following datapath what kind of value it holds. The six classes are zero, infinity, quiet NaN, signaling NaN, subnormal and normal. Each class has its own bit in a one-hot class vector.

Two optional modes clean up the operand before it moves on. With flush mode on, a subnormal becomes a zero that keeps its sign, and a one-cycle flush flag marks the event. With canonical-NaN mode on, every NaN is replaced by the quiet NaN 0x7FC00000. The class vector always describes the operand as it arrived, not the replacement.

A strobe qualifies the input. All results are registered, and they appear with an output valid one clock after the strobe.

Top module: `fpc_class_stage`

## Requirements
- R1: While reset is held, and after it until the first strobe, `out_valid`, `out_flushed`, `out_class` and `out_operand` are all zero.
- R2: A strobe on `in_valid` at a rising clock edge makes `out_valid` high after that edge for exactly one cycle. The other outputs update at the same edge. An edge without a strobe drives `out_valid` low and leaves `out_class` and `out_operand` unchanged.
- R3: `out_class` uses these bit positions: bit 0 zero, bit 1 infinity, bit 2 quiet NaN, bit 3 signaling NaN, bit 4 subnormal, bit 5 normal. Exactly one bit is set for every result reported with `out_valid`.
- R4: An exponent field (bits 30:23) of zero with a fraction (bits 22:0) of zero is class zero. An exponent of all ones with a zero fraction is class infinity. For both classes, `out_operand` equals the input, including the sign bit 31.
- R5: An all-ones exponent with a nonzero fraction is a NaN. Fraction bit 22 set makes it quiet, and clear makes it signaling.
- R6: A zero exponent with a nonzero fraction is class subnormal. An exponent from 1 to 254 is class normal.
- R7: With `mode_flush` high, a subnormal input gives an `out_operand` of the input sign followed by 31 zero bits. `out_class` still shows subnormal, and `out_flushed` is high for that result.
- R8: `out_flushed` is low in every cycle that does not follow a strobe that carried a subnormal with `mode_flush` high.
- R9: With `mode_dnan` high, any NaN input gives `out_operand` = 0x7FC00000. `out_class` still shows the quiet or signaling class of the input.
- R10: When neither mode applies to the input's class, `out_operand` equals `in_operand`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe qualifying the operand and modes |
| in_operand | input | 32 | Operand to classify |
| mode_flush | input | 1 | Enables subnormal-to-zero replacement |
| mode_dnan | input | 1 | Enables canonical quiet NaN replacement |
| out_valid | output | 1 | Registered results are fresh this cycle |
| out_class | output | 6 | One-hot class of the input |
| out_operand | output | 32 | Operand after mode substitution |
| out_flushed | output | 1 | A subnormal was flushed in this result |

## Verification
Both modes can be enabled on the same strobe. The bench provokes this by asserting `mode_flush` and `mode_dnan` together for subnormal, NaN, normal and zero operands, both in directed cases and in a long pseudo-random sweep that toggles each mode on its own. Because the classes are disjoint, at most one substitution may act on a given operand. A NaN with both modes on must come out as the canonical NaN with the flush flag low. A subnormal with both modes on must come out as a signed zero with the flag high. Operands of any other class must pass through bit-exact. Every cycle is compared against a behavioural model in the bench that tracks which values the outputs should hold.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int unsigned NUM_CLASS = 6;

    typedef enum int unsigned {
        CLS_ZERO = 0,
        CLS_INF  = 1,
        CLS_QNAN = 2,
        CLS_SNAN = 3,
        CLS_SUB  = 4,
        CLS_NORM = 5
    } cls_idx_e;

    typedef struct packed {
        logic sign;
        logic exp_zero;
        logic exp_ones;
        logic frac_zero;
        logic frac_msb;
    } field_info_t;

endpackage

// File: rtl/fpc_field_split.sv
module fpc_field_split #(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0]   operand,
    output fpc_pkg::field_info_t info
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f          = operand[WORD_W-2 -: EXP_W];
        frac_f         = operand[FRAC_W-1:0];
        info.sign      = operand[WORD_W-1];
        info.exp_zero  = (exp_f == '0);
        info.exp_ones  = (exp_f == '1);
        info.frac_zero = (frac_f == '0);
        info.frac_msb  = frac_f[FRAC_W-1];
    end
endmodule

// File: rtl/fpc_class_onehot.sv
module fpc_class_onehot
    import fpc_pkg::*;
(
    input  field_info_t          info,
    output logic [NUM_CLASS-1:0] cls
);
    always_comb begin
        cls           = '0;
        cls[CLS_ZERO] = info.exp_zero &  info.frac_zero;
        cls[CLS_SUB]  = info.exp_zero & ~info.frac_zero;
        cls[CLS_INF]  = info.exp_ones &  info.frac_zero;
        cls[CLS_QNAN] = info.exp_ones & ~info.frac_zero &  info.frac_msb;
        cls[CLS_SNAN] = info.exp_ones & ~info.frac_zero & ~info.frac_msb;
        cls[CLS_NORM] = ~info.exp_zero & ~info.exp_ones;
    end
endmodule

// File: rtl/fpc_sanitise.sv
module fpc_sanitise
    import fpc_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0]    operand,
    input  logic [NUM_CLASS-1:0] cls,
    input  logic                 flush_en,
    input  logic                 dnan_en,
    output logic [WORD_W-1:0]    result,
    output logic                 flushed
);
    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic is_nan;

    always_comb begin
        is_nan  = cls[CLS_QNAN] | cls[CLS_SNAN];
        flushed = flush_en & cls[CLS_SUB];
        result  = operand;
        if (flushed) begin
            result = {operand[WORD_W-1], {(WORD_W-1){1'b0}}};
        end else if (dnan_en & is_nan) begin
            result = CANON_NAN;
        end
    end
endmodule

// File: rtl/fpc_class_stage.sv
module fpc_class_stage
    import fpc_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23,
    localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_operand,
    input  logic                 mode_flush,
    input  logic                 mode_dnan,
    output logic                 out_valid,
    output logic [NUM_CLASS-1:0] out_class,
    output logic [WORD_W-1:0]    out_operand,
    output logic                 out_flushed
);
    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic                 valid;
        logic [NUM_CLASS-1:0] cls;
        logic [WORD_W-1:0]    opnd;
        logic                 flushed;
    } stage_t;

    field_info_t          info;
    logic [NUM_CLASS-1:0] cls_c;
    logic [WORD_W-1:0]    opnd_c;
    logic                 flushed_c;
    stage_t               st_d, st_q;

    fpc_field_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_split (
        .operand (in_operand),
        .info    (info)
    );

    fpc_class_onehot u_class (
        .info (info),
        .cls  (cls_c)
    );

    fpc_sanitise #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sanitise (
        .operand  (in_operand),
        .cls      (cls_c),
        .flush_en (mode_flush),
        .dnan_en  (mode_dnan),
        .result   (opnd_c),
        .flushed  (flushed_c)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.flushed = 1'b0;
        if (in_valid) begin
            st_d.cls     = cls_c;
            st_d.opnd    = opnd_c;
            st_d.flushed = flushed_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.valid;
    assign out_class   = st_q.cls;
    assign out_operand = st_q.opnd;
    assign out_flushed = st_q.flushed;

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_hold_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(out_class) && $stable(out_operand)));

    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_class) == 1));

    assert_flush_gives_signed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_flushed |-> (out_class[CLS_SUB] && out_operand[WORD_W-2:0] == '0
                         && out_operand[WORD_W-1] == $past(in_operand[WORD_W-1])));

    assert_flush_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_flushed |-> ($past(mode_flush) && $past(in_valid)));

    assert_canon_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_dnan) && (out_class[CLS_QNAN] || out_class[CLS_SNAN]))
        |-> (out_operand == CANON_NAN));

    assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_class[CLS_ZERO] || out_class[CLS_INF] || out_class[CLS_NORM]))
        |-> (out_operand == $past(in_operand)));
endmodule

// File: tb/fpc_class_stage_bench.sv
`timescale 1ns/1ps
module fpc_class_stage_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        mode_flush = 1'b0;
    logic        mode_dnan = 1'b0;
    logic        out_valid;
    logic [5:0]  out_class;
    logic [31:0] out_operand;
    logic        out_flushed;

    int checks = 0;
    int errors = 0;

    logic        exp_valid = 1'b0;
    logic [5:0]  exp_class = '0;
    logic [31:0] exp_opnd = '0;
    logic        exp_flush = 1'b0;

    always #2 clk = ~clk;

    fpc_class_stage u_fpc_class_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .mode_flush(mode_flush), .mode_dnan(mode_dnan), .out_valid(out_valid),
        .out_class(out_class), .out_operand(out_operand), .out_flushed(out_flushed)
    );

    function automatic logic [5:0] ref_class(input logic [31:0] x);
        int e = int'(x[30:23]);
        int f = int'(x[22:0]);
        if (e == 0 && f == 0)   return 6'b000001;
        if (e == 0)             return 6'b010000;
        if (e == 255 && f == 0) return 6'b000010;
        if (e == 255)           return x[22] ? 6'b000100 : 6'b001000;
        return 6'b100000;
    endfunction

    task automatic compare(input string req);
        checks++;
        if (out_valid !== exp_valid || out_class !== exp_class ||
            out_operand !== exp_opnd || out_flushed !== exp_flush) begin
            errors++;
            $display("FAIL %s: got v=%b cls=%b op=%h fl=%b, want v=%b cls=%b op=%h fl=%b",
                     req, out_valid, out_class, out_operand, out_flushed,
                     exp_valid, exp_class, exp_opnd, exp_flush);
        end
    endtask

    // Called at a falling edge; drives, models the next rising edge, checks at the next falling edge.
    task automatic step(input logic v, input logic [31:0] op, input logic f,
                        input logic d, input string req);
        logic [5:0] c;
        in_valid = v; in_operand = op; mode_flush = f; mode_dnan = d;
        c = ref_class(op);
        exp_valid = v;
        exp_flush = 1'b0;
        if (v) begin
            exp_class = c;
            exp_opnd  = op;
            if (f && c == 6'b010000) begin
                exp_opnd  = {op[31], 31'd0};
                exp_flush = 1'b1;
            end else if (d && (c == 6'b000100 || c == 6'b001000)) begin
                exp_opnd = 32'h7FC00000;
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        @(negedge clk); @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");
        step(1'b0, 32'h3F800000, 1'b1, 1'b1, "R1 idle keeps zero");

        step(1'b1, 32'h00000000, 1'b0, 1'b0, "R4 +0");
        step(1'b1, 32'h80000000, 1'b1, 1'b1, "R4 -0");
        step(1'b1, 32'h7F800000, 1'b0, 1'b0, "R4 +inf");
        step(1'b1, 32'hFF800000, 1'b1, 1'b1, "R4 -inf");
        step(1'b1, 32'h7FC00001, 1'b0, 1'b0, "R5 qnan");
        step(1'b1, 32'hFFBFFFFF, 1'b0, 1'b0, "R5 snan");
        step(1'b1, 32'h7F800001, 1'b0, 1'b0, "R5 snan min");
        step(1'b1, 32'h00000001, 1'b0, 1'b0, "R6 subnormal min");
        step(1'b1, 32'h807FFFFF, 1'b0, 1'b0, "R6 subnormal max");
        step(1'b1, 32'h00800000, 1'b0, 1'b0, "R6 normal min");
        step(1'b1, 32'hFF7FFFFF, 1'b1, 1'b1, "R6 R10 normal max");
        step(1'b1, 32'hC0E00000, 1'b1, 1'b1, "R10 normal");
        step(1'b1, 32'h00400000, 1'b1, 1'b0, "R7 flush +sub");
        step(1'b1, 32'h80000003, 1'b1, 1'b1, "R7 flush -sub both modes");
        step(1'b0, 32'h00000005, 1'b1, 1'b1, "R2 R8 idle hold");
        step(1'b0, 32'h7F800001, 1'b1, 1'b1, "R2 idle hold 2");
        step(1'b1, 32'h7FA12345, 1'b0, 1'b1, "R9 dnan snan");
        step(1'b1, 32'hFFFFFFFF, 1'b1, 1'b1, "R9 dnan qnan both modes");
        step(1'b1, 32'h7FC00000, 1'b0, 1'b1, "R9 canonical in");
        step(1'b1, 32'h00000001, 1'b0, 1'b1, "R8 dnan only sub");

        lfsr = 32'hACE1_2B3D;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] op;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            op = lfsr;
            case (lfsr[3:2])
                2'd0: op[30:23] = 8'h00;
                2'd1: op[30:23] = 8'hFF;
                default: ;
            endcase
            if (lfsr[9:5] == 5'd0) op[22:0] = '0;
            step(lfsr[4] | lfsr[12], op, lfsr[7], lfsr[8], "R3 R7 R9 R10 sweep");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule